// File: doc/BRIEF.md
# Fusing Instruction Queue

This block buffers pre-marked instructions between the boundary marker and the decoder. Each cycle it can take up to five instruction descriptors from upstream. Each descriptor holds a byte length, a start offset inside the fetch window and a class code. Each cycle it presents up to five decode slots downstream. While it fills those slots it looks for a simple arithmetic operation that is directly followed by a conditional jump. Such a pair leaves as one fused slot, so a single slot can retire two queue entries.

The queue is a 16-entry circular store. Upstream may present a new group only while five entries are free. Downstream takes every valid slot in one go when it raises its ready input. An arithmetic entry at the tail of the queue, with no successor yet, can be withheld for one cycle so that a jump arriving next can still fuse with it. A flush input empties the store in one cycle.

Top module: `fiq_fuse_top`

## Requirements
- R1: After reset no output slot is valid and in_ready_o is high.
- R2: in_ready_o is high exactly when flush_i is low and the queue holds at most DEPTH-LANES entries (11 by default). At a rising edge with in_ready_o high, the leading run of valid lanes, starting at lane 0, is appended in lane order. A lane after the first invalid lane is not taken. An appended entry can show in a slot from the next cycle on.
- R3: Class code 2'b01 marks simple arithmetic, 2'b10 marks a conditional jump, and any other code marks other instructions. An arithmetic entry directly followed by a jump entry leaves as one slot. That slot has fused=1, len0 set to the arithmetic length, len1 set to the jump length and off set to the arithmetic offset.
- R4: An unfused slot has fused=0, len1=0, and len0 and off set to its own instruction. A length is 1 to 15, and upstream never presents 0 on a valid lane.
- R5: At most five slots are valid per cycle, and they are packed from slot 0 in program order. A fused pair takes one slot, so up to ten entries can retire in one cycle.
- R6: An arithmetic entry is never fused with a jump that is not its immediate successor. An arithmetic entry followed by a non-jump leaves alone. In the order arithmetic, arithmetic, jump, the second arithmetic fuses.
- R7: An arithmetic entry that is the last in the queue is withheld for that cycle when at least one earlier slot is filled in the same cycle. If it would take slot 0, it leaves unfused.
- R8: While out_ready_i is low no slot is consumed and the head slot is kept. When out_ready_i is high, all valid slots are consumed at that edge.
- R9: In a cycle with flush_i high, no slot is valid and no input is taken. In the next cycle the queue is empty.
- R10: Instructions leave in the order they were accepted across any number of cycles, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all queued entries |
| in_valid_i | input | LANES | Lane valid, bit k for lane k |
| in_len_i | input | LANES*4 | Lane k length at bits [4k+3:4k] |
| in_off_i | input | LANES*5 | Lane k start offset at bits [5k+4:5k] |
| in_cls_i | input | LANES*2 | Lane k class at bits [2k+1:2k] |
| in_ready_o | output | 1 | Queue can take a full group |
| out_valid_o | output | LANES | Slot valid, bit k for slot k |
| out_fused_o | output | LANES | Slot k holds a fused pair |
| out_len0_o | output | LANES*4 | Slot k first length at bits [4k+3:4k] |
| out_len1_o | output | LANES*4 | Slot k second length, 0 if unfused |
| out_off_o | output | LANES*5 | Slot k start offset at bits [5k+4:5k] |
| out_ready_i | input | 1 | Downstream takes all valid slots |

## Verification
Two functions can meet in one cycle: the tail hold and the arrival of the jump that completes the pair. The bench provokes this by presenting an other-then-arithmetic group and then, in the very next cycle, a lone jump. In that cycle the other instruction retires, the arithmetic entry is withheld, and the jump is enqueued. The bench judges it by requiring one slot in the hold cycle and one fused slot in the cycle after, with the lengths and offset that the scoreboard predicts. A second collision, a flush arriving together with an input group, is judged by finding no slots valid and no space consumed afterwards.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int LEN_W = 4;
  localparam int OFF_W = 5;
  localparam int CLS_W = 2;

  localparam logic [CLS_W-1:0] CLS_ARITH = 2'd1;
  localparam logic [CLS_W-1:0] CLS_JCC   = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
    logic [CLS_W-1:0] cls;
  } fiq_ent_t;

  typedef struct packed {
    logic             fused;
    logic [LEN_W-1:0] len0;
    logic [LEN_W-1:0] len1;
    logic [OFF_W-1:0] off;
  } fiq_slot_t;
endpackage

// File: rtl/fiq_store.sv
module fiq_store
  import fiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int WIN   = 2 * LANES,
  localparam int RET_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] enq_n_i,
  input  fiq_ent_t         enq_ent_i [LANES],
  input  logic [RET_W-1:0] deq_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output fiq_ent_t         win_o [WIN],
  output logic [WIN-1:0]   win_vld_o
);
  fiq_ent_t         mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_q + PTR_W'(deq_n_i);
      wr_ptr_q <= wr_ptr_q + PTR_W'(enq_n_i);
      cnt_q    <= cnt_q + enq_n_i - CNT_W'(deq_n_i);
    end
  end

  // storage carries no reset; validity comes from cnt_q
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (CNT_W'(k) < enq_n_i) mem_q[wr_ptr_q + PTR_W'(k)] <= enq_ent_i[k];
    end
  end

  for (genvar k = 0; k < WIN; k++) begin : g_win
    assign win_o[k]     = mem_q[rd_ptr_q + PTR_W'(k)];
    assign win_vld_o[k] = cnt_q > CNT_W'(k);
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_q) + int'(enq_n_i)) <= DEPTH); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(deq_n_i) <= int'(cnt_q)); // R5
endmodule

// File: rtl/fiq_pair_sel.sv
module fiq_pair_sel
  import fiq_pkg::*;
#(
  parameter int LANES = 5,
  localparam int WIN   = 2 * LANES,
  localparam int RET_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fiq_ent_t         win_i [WIN],
  input  logic [WIN-1:0]   win_vld_i,
  output fiq_slot_t        slot_o [LANES],
  output logic [LANES-1:0] slot_vld_o,
  output logic [RET_W-1:0] ret_n_o
);
  logic [RET_W-1:0] p, q;
  logic             stop, nxt_ok;

  // slot s reads window entry p <= 2s, so q = p+1 stays inside the window
  always_comb begin
    p      = '0;
    q      = '0;
    stop   = 1'b0;
    nxt_ok = 1'b0;
    for (int s = 0; s < LANES; s++) begin
      slot_o[s]     = '0;
      slot_vld_o[s] = 1'b0;
      if (!stop && win_vld_i[p]) begin
        q      = p + RET_W'(1);
        nxt_ok = win_vld_i[q];
        if (win_i[p].cls == CLS_ARITH && nxt_ok && win_i[q].cls == CLS_JCC) begin
          slot_vld_o[s]  = 1'b1;
          slot_o[s].fused = 1'b1;
          slot_o[s].len0  = win_i[p].len;
          slot_o[s].len1  = win_i[q].len;
          slot_o[s].off   = win_i[p].off;
          p = p + RET_W'(2);
        end else if (win_i[p].cls == CLS_ARITH && !nxt_ok && s != 0) begin
          stop = 1'b1; // tail arithmetic waits for a possible jump
        end else begin
          slot_vld_o[s]  = 1'b1;
          slot_o[s].len0 = win_i[p].len;
          slot_o[s].off  = win_i[p].off;
          p = p + RET_W'(1);
        end
      end
    end
    ret_n_o = p;
  end

  for (genvar k = 1; k < LANES; k++) begin : g_pack
    AST_SLOTS_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[k] |-> slot_vld_o[k-1]); // R5
  end

  AST_RETIRE_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(slot_vld_o) <= int'(ret_n_o)) &&
    (int'(ret_n_o) <= 2 * $countones(slot_vld_o))); // R5
endmodule

// File: rtl/fiq_fuse_top.sv
module fiq_fuse_top
  import fiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [LANES-1:0]       in_valid_i,
  input  logic [LANES*LEN_W-1:0] in_len_i,
  input  logic [LANES*OFF_W-1:0] in_off_i,
  input  logic [LANES*CLS_W-1:0] in_cls_i,
  output logic                   in_ready_o,
  output logic [LANES-1:0]       out_valid_o,
  output logic [LANES-1:0]       out_fused_o,
  output logic [LANES*LEN_W-1:0] out_len0_o,
  output logic [LANES*LEN_W-1:0] out_len1_o,
  output logic [LANES*OFF_W-1:0] out_off_o,
  input  logic                   out_ready_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WIN   = 2 * LANES;
  localparam int RET_W = $clog2(WIN + 1);

  fiq_ent_t         enq_ent [LANES];
  fiq_ent_t         win     [WIN];
  fiq_slot_t        slot    [LANES];
  logic [WIN-1:0]   win_vld;
  logic [LANES-1:0] slot_vld;
  logic [CNT_W-1:0] lead_n, enq_n, cnt;
  logic [RET_W-1:0] ret_n, deq_n;
  logic             run;

  always_comb begin
    lead_n = '0;
    run    = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      enq_ent[k].len = in_len_i[k*LEN_W +: LEN_W];
      enq_ent[k].off = in_off_i[k*OFF_W +: OFF_W];
      enq_ent[k].cls = in_cls_i[k*CLS_W +: CLS_W];
      if (run && in_valid_i[k]) lead_n = lead_n + CNT_W'(1);
      else                      run    = 1'b0;
    end
  end

  assign in_ready_o = !flush_i && (int'(cnt) <= DEPTH - LANES);
  assign enq_n      = in_ready_o ? lead_n : '0;
  assign deq_n      = (out_ready_i && !flush_i) ? ret_n : '0;

  fiq_store #(.DEPTH(DEPTH), .LANES(LANES)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .enq_n_i   (enq_n),
    .enq_ent_i (enq_ent),
    .deq_n_i   (deq_n),
    .cnt_o     (cnt),
    .win_o     (win),
    .win_vld_o (win_vld)
  );

  fiq_pair_sel #(.LANES(LANES)) sel_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_i      (win),
    .win_vld_i  (win_vld),
    .slot_o     (slot),
    .slot_vld_o (slot_vld),
    .ret_n_o    (ret_n)
  );

  always_comb begin
    out_valid_o = flush_i ? '0 : slot_vld;
    out_fused_o = '0;
    out_len0_o  = '0;
    out_len1_o  = '0;
    out_off_o   = '0;
    for (int k = 0; k < LANES; k++) begin
      out_fused_o[k]               = slot[k].fused;
      out_len0_o[k*LEN_W +: LEN_W] = slot[k].len0;
      out_len1_o[k*LEN_W +: LEN_W] = slot[k].len1;
      out_off_o[k*OFF_W +: OFF_W]  = slot[k].off;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_FUSED_HAS_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[k] && out_fused_o[k]) |-> (out_len1_o[k*LEN_W +: LEN_W] != '0)); // R3
    AST_SINGLE_NO_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[k] && !out_fused_o[k]) |-> (out_len1_o[k*LEN_W +: LEN_W] == '0)); // R4
    AST_SLOT_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> (out_len0_o[k*LEN_W +: LEN_W] != '0)); // R4
    AST_IN_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[k] && in_ready_o) |-> (in_len_i[k*LEN_W +: LEN_W] != '0)); // R4
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (out_valid_o == '0)); // R9
  AST_STALL_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o[0] && !out_ready_i && !flush_i) |=> $stable(out_off_o[OFF_W-1:0])); // R8
endmodule

// File: tb/fiq_fuse_top_tb_top.sv
`timescale 1ns/1ps
module fiq_fuse_top_tb_top;
  localparam int L = 5, LW = 4, OW = 5, CW = 2;
  localparam int A = 1, J = 2, O = 0;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, out_ready = 1'b0;
  logic [L-1:0]    in_valid = '0;
  logic [L*LW-1:0] in_len = '0;
  logic [L*OW-1:0] in_off = '0;
  logic [L*CW-1:0] in_cls = '0;
  logic            in_ready_o;
  logic [L-1:0]    out_valid_o, out_fused_o;
  logic [L*LW-1:0] out_len0_o, out_len1_o;
  logic [L*OW-1:0] out_off_o;

  always #4 clk = ~clk;

  fiq_fuse_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_len_i(in_len), .in_off_i(in_off), .in_cls_i(in_cls),
    .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_fused_o(out_fused_o),
    .out_len0_o(out_len0_o), .out_len1_o(out_len1_o), .out_off_o(out_off_o),
    .out_ready_i(out_ready)
  );

  typedef struct {int fused; int l0; int l1; int off;} exp_t;
  exp_t sbq[$];
  int checks = 0, fails = 0, gid = 0, t_n = 0;
  int t_cls[64], t_len[64], t_off[64];

  function automatic void add(int c);
    t_cls[t_n] = c; t_len[t_n] = (gid % 15) + 1; t_off[t_n] = (gid * 7 + 3) % 32;
    t_n++; gid++;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void push_one(int i);
    exp_t e; e.fused = 0; e.l0 = t_len[i]; e.l1 = 0; e.off = t_off[i]; sbq.push_back(e);
  endfunction

  function automatic void push_pair(int i);
    exp_t e; e.fused = 1; e.l0 = t_len[i]; e.l1 = t_len[i+1]; e.off = t_off[i]; sbq.push_back(e);
  endfunction

  // fusion over a fully present sequence, from R3/R6
  function automatic void expect_greedy(int first, int n);
    int i = first;
    while (i < first + n) begin
      if (t_cls[i] == A && i + 1 < first + n && t_cls[i+1] == J) begin push_pair(i); i += 2; end
      else begin push_one(i); i += 1; end
    end
  endfunction

  task automatic set_lanes(int first, int n);
    in_valid = '0;
    for (int k = 0; k < n; k++) begin
      in_valid[k] = 1'b1;
      in_len[k*LW +: LW] = LW'(t_len[first+k]);
      in_off[k*OW +: OW] = OW'(t_off[first+k]);
      in_cls[k*CW +: CW] = CW'(t_cls[first+k]);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive_batch(int first, int n);
    set_lanes(first, n);
    do @(negedge clk); while (!in_ready_o);
    @(posedge clk); #1;
    in_valid = '0;
  endtask

  // monitor: every consumed slot is compared with the scoreboard (R3 R4 R10)
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && out_ready && !flush) begin
      for (int k = 0; k < L; k++) begin
        if (out_valid_o[k]) begin
          checks++;
          if (sbq.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected slot %0d act off=%0d exp none", k, out_off_o[k*OW +: OW]);
          end else begin
            e = sbq.pop_front();
            if (int'(out_fused_o[k]) != e.fused || int'(out_len0_o[k*LW +: LW]) != e.l0 ||
                int'(out_len1_o[k*LW +: LW]) != e.l1 || int'(out_off_o[k*OW +: OW]) != e.off) begin
              fails++;
              $display("FAIL R3 R4 R10 slot %0d act f=%0d l0=%0d l1=%0d off=%0d exp f=%0d l0=%0d l1=%0d off=%0d",
                       k, out_fused_o[k], out_len0_o[k*LW +: LW], out_len1_o[k*LW +: LW],
                       out_off_o[k*OW +: OW], e.fused, e.l0, e.l1, e.off);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid_o), 0);
    chk("R1 ready after reset", int'(in_ready_o), 1);
    step();

    // fill to the ready threshold while stalled
    out_ready = 1'b0; t_n = 0;
    add(A); add(J); add(O); add(A); add(O); add(A); add(A); add(J); add(J); add(O); add(A); add(J);
    drive_batch(0, 5); drive_batch(5, 5); drive_batch(10, 1);
    @(negedge clk); chk("R2 ready with 11 held", int'(in_ready_o), 1);
    step();
    drive_batch(11, 1);
    @(negedge clk);
    chk("R2 ready with 12 held", int'(in_ready_o), 0);
    chk("R8 head offset while stalled", int'(out_off_o[OW-1:0]), t_off[0]);
    chk("R5 slot count capped", $countones(out_valid_o), 5);
    chk("R3 fused slot map", int'(out_fused_o), 1);
    step(); step();
    @(negedge clk);
    chk("R8 head kept after stall", int'(out_off_o[OW-1:0]), t_off[0]);
    chk("R8 slots kept after stall", $countones(out_valid_o), 5);
    step();
    expect_greedy(0, 12);
    out_ready = 1'b1;
    @(negedge clk); chk("R5 first drain cycle", $countones(out_valid_o), 5);
    step();
    @(negedge clk); chk("R5 second drain cycle", $countones(out_valid_o), 4);
    step();
    @(negedge clk); chk("R8 all consumed", int'(out_valid_o), 0);
    step();

    // hold meets the arriving jump
    t_n = 0; add(O); add(A); add(J);
    expect_greedy(0, 3);
    drive_batch(0, 2);
    set_lanes(2, 1);
    @(negedge clk);
    chk("R7 tail arithmetic withheld", $countones(out_valid_o), 1);
    chk("R7 withheld cycle unfused", int'(out_fused_o[0]), 0);
    step(); in_valid = '0;
    @(negedge clk);
    chk("R7 one slot after hold", $countones(out_valid_o), 1);
    chk("R3 held pair fused", int'(out_fused_o[0]), 1);
    step();
    @(negedge clk); chk("R7 drained", int'(out_valid_o), 0);
    step();

    // hold with no successor
    t_n = 0; add(O); add(A);
    expect_greedy(0, 2);
    drive_batch(0, 2);
    @(negedge clk); chk("R7 hold without successor", $countones(out_valid_o), 1);
    step();
    @(negedge clk);
    chk("R7 released alone", $countones(out_valid_o), 1);
    chk("R7 released unfused", int'(out_fused_o[0]), 0);
    step();

    // arithmetic in slot 0 leaves at once
    t_n = 0; add(A); add(J);
    push_one(0); push_one(1);
    drive_batch(0, 1);
    @(negedge clk);
    chk("R7 slot0 arithmetic emitted", $countones(out_valid_o), 1);
    chk("R7 slot0 arithmetic unfused", int'(out_fused_o[0]), 0);
    step();
    drive_batch(1, 1);
    @(negedge clk); chk("R6 late jump unfused", int'(out_fused_o[0]), 0);
    step();

    // non-adjacent pairs
    out_ready = 1'b0; t_n = 0;
    add(A); add(O); add(J); add(A); add(A); add(J); add(O);
    drive_batch(0, 5); drive_batch(5, 2);
    @(negedge clk);
    chk("R6 fused map", int'(out_fused_o), 5'b10000);
    chk("R6 slot count", $countones(out_valid_o), 5);
    step();
    expect_greedy(0, 7);
    out_ready = 1'b1;
    step(); step();
    @(negedge clk); chk("R6 drained", int'(out_valid_o), 0);
    step();

    // ten entries in one cycle
    out_ready = 1'b0; t_n = 0;
    for (int i = 0; i < 5; i++) begin add(A); add(J); end
    drive_batch(0, 5); drive_batch(5, 5);
    @(negedge clk);
    chk("R5 five fused slots", int'(out_fused_o), 5'b11111);
    chk("R5 five valid", $countones(out_valid_o), 5);
    step();
    expect_greedy(0, 10);
    out_ready = 1'b1;
    step();
    @(negedge clk); chk("R5 ten retired at once", int'(out_valid_o), 0);
    step();

    // flush with a group offered in the same cycle
    out_ready = 1'b0; t_n = 0;
    for (int i = 0; i < 5; i++) add(O);
    add(A); add(J);
    drive_batch(0, 5);
    set_lanes(5, 2); flush = 1'b1;
    @(negedge clk);
    chk("R9 no slot during flush", int'(out_valid_o), 0);
    chk("R9 no ready during flush", int'(in_ready_o), 0);
    step(); flush = 1'b0; in_valid = '0;
    @(negedge clk);
    chk("R9 empty after flush", int'(out_valid_o), 0);
    chk("R9 ready after flush", int'(in_ready_o), 1);
    step();
    out_ready = 1'b1;
    expect_greedy(5, 2);
    drive_batch(5, 2);
    @(negedge clk); chk("R9 refill works", $countones(out_valid_o), 1);
    step();

    // back-to-back stream
    t_n = 0;
    for (int i = 0; i < 40; i++) begin
      int m = i % 7;
      if (i == 39) add(O);
      else if (m == 0 || m == 3 || m == 5) add(A);
      else if (m == 1 || m == 4) add(J);
      else add(O);
    end
    expect_greedy(0, 40);
    for (int b = 0; b < 8; b++) drive_batch(b * 5, 5);
    repeat (4) step();
    chk("R10 scoreboard drained", sbq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule